// File: doc/BRIEF.md
# Hearing-aid memory select controller

This block chooses which of four program memories (A, B, C, D, encoded 0 to 3 on `mem_sel`) a hearing aid runs. Two switch pins feed it. Each pin is sampled, passed through a two-flop synchronizer and turned into an "asserted" level. A polarity input tells the block whether a closed switch pulls the pin high or low. A two-bit mode picks one of four behaviours:

- momentary cycling on the first switch;
- momentary cycling with a static override on the second switch that forces memory D (used for an automatic telecoil driven by a reed switch);
- two static switches that encode the memory directly;
- two static switches with the same D override.

When the override drops, the block returns to the memory it held before the jump. It does so only after the second switch has stayed open without a break for a programmable number of samples. Momentary presses are debounced and counted once per closure, and they are ignored while a power-on delay flag is high. A one-cycle `mem_chg` pulse marks every real change of the index, so that a fader or an indicator-tone block can follow it.

The controller is a four-state machine:

- `ST_BOOT`: runs for three cycles after reset while the synchronizers fill, then goes to `ST_RUN`, or to `ST_HELD` if the override is asserted.
- `ST_RUN`: normal selection. It goes to `ST_HELD` when the override asserts.
- `ST_HELD`: memory D while the override switch is closed. It goes to `ST_RELEASE` on the first open sample.
- `ST_RELEASE`: memory D while the open-time counter runs. It goes back to `ST_HELD` on any closure, or to `ST_RUN` once the counter reaches the debounce length.

Top module: `memsel_ctrl`

## Requirements
- R1: While reset is applied, `mem_sel` is 0 (memory A) and `mem_chg` is 0. In a momentary mode with the override not asserted, memory A is still selected after boot.
- R2: A switch counts as asserted when its synchronized pin level XOR `pull_up` is 1 (pull_up=0: closed reads high; pull_up=1: closed reads low). The same polarity applies to both switches in every mode.
- R3: In momentary mode (`mode`=0), each press of switch 1 moves to the next higher memory whose `valid_mask` bit is set. From the highest valid memory it wraps to A. Bit 0 of the mask is always treated as valid.
- R4: With only memory A valid, a press leaves `mem_sel` at A and produces no `mem_chg` pulse.
- R5: In momentary D-only mode (`mode`=1), an asserted switch 2 forces memory D (3), and switch-1 presses are ignored while in D. After the release window the block returns to the memory active before the jump.
- R6: In momentary D-only mode, the highest valid memory is left out of the press cycle. Mask 1111 cycles A,B,C; mask 0111 cycles A,B.
- R7: In static mode (`mode`=2), the index is {switch2, switch1} of the asserted levels: neither → A, switch 1 only → B, switch 2 only → C, both → D. An invalid selection gives A. After boot the block starts in the selected memory, and changing the switches one at a time passes through the intermediate memory.
- R8: In static D-only mode (`mode`=3), an asserted switch 2 selects D whatever switch 1 is, including at boot. Otherwise switch 1 selects B (if valid) and its absence selects A, so C is never used.
- R9: In both D-only modes, D is left only after switch 2 has been open for at least `dbnc_len` consecutive synchronized samples, and within `dbnc_len`+4 cycles of the pin opening. Any closure restarts the count.
- R10: Presses are ignored while `por_hold` is 1.
- R11: `mem_chg` is high for exactly the cycles in which `mem_sel` differs from its value in the previous cycle.
- R12: A press counts only once switch 1 has stayed asserted for `PRESS_CYC` synchronized cycles. A held switch advances once per closure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw1_raw | input | 1 | Switch 1 pin level |
| sw2_raw | input | 1 | Switch 2 pin level |
| mode | input | 2 | 0 momentary, 1 momentary D-only, 2 static, 3 static D-only |
| pull_up | input | 1 | 1 when a closed switch reads low |
| valid_mask | input | 4 | Bit n set when memory n is programmed |
| dbnc_len | input | DBNC_W | Open-time window for leaving D, in samples |
| por_hold | input | 1 | Power-on delay active; presses ignored |
| mem_sel | output | 2 | Active memory index, A=0 to D=3 |
| mem_chg | output | 1 | One-cycle pulse on each index change |

## Verification
The assertions assume that `mode`, `pull_up` and `valid_mask` are configuration values that change only while reset is held. The invalid-selection and override checks rely on this. The stimulus respects it: every configuration change happens inside a reset pulse, and switch levels are driven on falling edges and held for many cycles at a time. The exception is the deliberate one-cycle closure used to restart the release window.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
    localparam int MEM_W   = 2;
    localparam int NUM_MEM = 1 << MEM_W;
    localparam logic [MEM_W-1:0] MEM_A = '0;
    localparam logic [MEM_W-1:0] MEM_D = MEM_W'(NUM_MEM - 1);
    localparam int BOOT_CYC = 2;

    typedef enum logic [1:0] {
        MODE_MOM          = 2'd0,
        MODE_MOM_DONLY    = 2'd1,
        MODE_STATIC       = 2'd2,
        MODE_STATIC_DONLY = 2'd3
    } sel_mode_e;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_HELD    = 2'd2,
        ST_RELEASE = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/memsel_sync.sv
module memsel_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/memsel_press.sv
module memsel_press #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    localparam int CW = $clog2(STABLE + 1);

    logic          db;
    logic [CW-1:0] cnt;

    // The filtered level flips only after STABLE samples that disagree with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db   <= 1'b0;
            cnt  <= '0;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (lvl == db) begin
                cnt <= '0;
            end else if (cnt == CW'(STABLE - 1)) begin
                db   <= lvl;
                cnt  <= '0;
                rise <= lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/memsel_pick.sv
module memsel_pick
    import memsel_pkg::*;
(
    input  logic [MEM_W-1:0]   cur,
    input  logic [NUM_MEM-1:0] valid_mask,
    input  logic               donly,
    input  logic               sw1_on,
    input  logic               sw2_on,
    output logic [MEM_W-1:0]   cyc_next,
    output logic [MEM_W-1:0]   st_sel,
    output logic [MEM_W-1:0]   sd_sel
);
    logic [NUM_MEM-1:0] allowed;
    logic [MEM_W-1:0]   top;
    logic [MEM_W-1:0]   enc;

    // Next memory in the press cycle: smallest allowed index above cur, else A.
    always_comb begin
        allowed    = valid_mask;
        allowed[0] = 1'b1;
        top        = MEM_A;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (allowed[i]) top = MEM_W'(i);
        end
        if (donly && (top != MEM_A)) allowed[top] = 1'b0;
        cyc_next = MEM_A;
        for (int i = NUM_MEM - 1; i >= 1; i--) begin
            if (allowed[i] && (MEM_W'(i) > cur)) cyc_next = MEM_W'(i);
        end
    end

    // Static selections.
    always_comb begin
        enc    = {sw2_on, sw1_on};
        st_sel = valid_mask[enc] ? enc : MEM_A;
        sd_sel = (sw1_on && valid_mask[1]) ? MEM_W'(1) : MEM_A;
    end
endmodule

// File: rtl/memsel_ctrl.sv
module memsel_ctrl
    import memsel_pkg::*;
#(
    parameter int PRESS_CYC = 4,
    parameter int DBNC_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw1_raw,
    input  logic              sw2_raw,
    input  logic [1:0]        mode,
    input  logic              pull_up,
    input  logic [3:0]        valid_mask,
    input  logic [DBNC_W-1:0] dbnc_len,
    input  logic              por_hold,
    output logic [1:0]        mem_sel,
    output logic              mem_chg
);
    sel_mode_e   mode_e;
    ctl_state_e  state_q, state_d;
    logic [1:0]  sw_sync;
    logic        sw1_on, sw2_on, press;
    logic        donly, is_static;
    logic        in_d, booting;
    logic [MEM_W-1:0]  mem_q, mem_d, saved_q, saved_d;
    logic [MEM_W-1:0]  cyc_next, st_sel, sd_sel, run_sel;
    logic [DBNC_W-1:0] cnt_q, cnt_d;

    assign mode_e    = sel_mode_e'(mode);
    assign donly     = mode[0];
    assign is_static = mode[1];

    memsel_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sw2_raw, sw1_raw}),
        .dout (sw_sync)
    );

    assign sw1_on = sw_sync[0] ^ pull_up;
    assign sw2_on = sw_sync[1] ^ pull_up;

    memsel_press #(.STABLE(PRESS_CYC)) u_press (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sw1_on),
        .rise (press)
    );

    memsel_pick u_pick (
        .cur       (mem_q),
        .valid_mask(valid_mask),
        .donly     (donly),
        .sw1_on    (sw1_on),
        .sw2_on    (sw2_on),
        .cyc_next  (cyc_next),
        .st_sel    (st_sel),
        .sd_sel    (sd_sel)
    );

    // Memory chosen in ST_RUN when no override is present.
    always_comb begin
        unique case (mode_e)
            MODE_STATIC:       run_sel = st_sel;
            MODE_STATIC_DONLY: run_sel = sd_sel;
            default:           run_sel = (press && !por_hold) ? cyc_next : mem_q;
        endcase
    end

    // Next-state and next-data logic.
    always_comb begin
        state_d = state_q;
        mem_d   = mem_q;
        saved_d = saved_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_BOOT: begin
                if (cnt_q == DBNC_W'(BOOT_CYC)) begin
                    cnt_d = '0;
                    if (donly && sw2_on) begin
                        state_d = ST_HELD;
                        mem_d   = MEM_D;
                        saved_d = (mode_e == MODE_STATIC_DONLY) ? sd_sel : MEM_A;
                    end else begin
                        state_d = ST_RUN;
                        mem_d   = is_static ? run_sel : MEM_A;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (donly && sw2_on) begin
                    state_d = ST_HELD;
                    saved_d = mem_q;
                    mem_d   = MEM_D;
                end else begin
                    mem_d = run_sel;
                end
            end
            ST_HELD: begin
                if (!sw2_on) begin
                    state_d = ST_RELEASE;
                    cnt_d   = DBNC_W'(1);
                end
            end
            ST_RELEASE: begin
                if (sw2_on) begin
                    state_d = ST_HELD;
                    cnt_d   = '0;
                end else if (cnt_q >= dbnc_len) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                    mem_d   = (mode_e == MODE_STATIC_DONLY) ? sd_sel : saved_q;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Output and data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q   <= MEM_A;
            saved_q <= MEM_A;
            cnt_q   <= '0;
            mem_chg <= 1'b0;
        end else begin
            mem_q   <= mem_d;
            saved_q <= saved_d;
            cnt_q   <= cnt_d;
            mem_chg <= (mem_d != mem_q);
        end
    end

    assign mem_sel = mem_q;
    assign in_d    = (state_q == ST_HELD) || (state_q == ST_RELEASE);
    assign booting = (state_q == ST_BOOT);
endmodule

// File: rtl/memsel_chk.sv
module memsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [3:0] valid_mask,
    input logic       por_hold,
    input logic       sw2_on,
    input logic       in_d,
    input logic       booting,
    input logic [1:0] mem_sel,
    input logic       mem_chg
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R11
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (mem_chg == (mem_sel != $past(mem_sel))));

    // R5
    force_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!booting && mode[0] && sw2_on) |=> (mem_sel == 2'd3));

    // R6
    d_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && (mem_sel == 2'd3)) |-> in_d);

    // R9
    closure_keeps_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_d && sw2_on) |=> in_d);

    // R10
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!booting && (mode == 2'd0) && por_hold) |=> $stable(mem_sel));

    // R3
    valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[0]) |-> ((mem_sel == 2'd0) || valid_mask[mem_sel]));
endmodule

bind memsel_ctrl memsel_chk u_memsel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .valid_mask(valid_mask),
    .por_hold  (por_hold),
    .sw2_on    (sw2_on),
    .in_d      (in_d),
    .booting   (booting),
    .mem_sel   (mem_sel),
    .mem_chg   (mem_chg)
);

// File: tb/memsel_ctrl_bench.sv
module memsel_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw1_raw = 1'b0, sw2_raw = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       pull_up = 1'b0;
    logic [3:0] vmask = 4'hF;
    logic [7:0] dbnc = 8'd20;
    logic       por_hold = 1'b0;
    logic [1:0] mem_sel;
    logic       mem_chg;

    int  n_chk = 0, n_err = 0, chg_err = 0;
    bit  a1 = 0, a2 = 0, done = 0, prev_ok = 0;
    logic [1:0] prev = 2'd0;

    always #4 clk = ~clk;

    memsel_ctrl u_memsel_ctrl (
        .clk(clk), .rst_n(rst_n), .sw1_raw(sw1_raw), .sw2_raw(sw2_raw),
        .mode(mode), .pull_up(pull_up), .valid_mask(vmask), .dbnc_len(dbnc),
        .por_hold(por_hold), .mem_sel(mem_sel), .mem_chg(mem_chg)
    );

    // R11 monitor: pulse exactly when the index differs from the previous cycle.
    always @(negedge clk) begin
        if (rst_n && prev_ok && (mem_chg !== (mem_sel != prev))) chg_err++;
        prev    = mem_sel;
        prev_ok = rst_n;
    end

    function automatic logic [1:0] exp_next(logic [1:0] cur, logic [3:0] m, bit donly);
        logic [3:0] ok;
        ok = m | 4'b0001;
        if (donly) begin
            if (ok[3]) ok[3] = 1'b0;
            else if (ok[2]) ok[2] = 1'b0;
            else if (ok[1]) ok[1] = 1'b0;
        end
        for (int k = int'(cur) + 1; k < 4; k++) if (ok[k]) return 2'(k);
        return 2'd0;
    endfunction

    function automatic logic [1:0] exp_static(bit s1, bit s2, logic [3:0] m);
        logic [1:0] e;
        e = {s2, s1};
        return m[e] ? e : 2'd0;
    endfunction

    task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: mem_sel=%0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive();
        sw1_raw = a1 ^ pull_up;
        sw2_raw = a2 ^ pull_up;
    endtask

    task automatic boot(logic [1:0] md, bit pu, logic [3:0] m, logic [7:0] p, bit s1, bit s2);
        @(negedge clk);
        rst_n = 1'b0;
        mode = md; pull_up = pu; vmask = m; dbnc = p;
        a1 = s1; a2 = s2; drive();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic press(int hold);
        a1 = 1; drive();
        repeat (hold) @(negedge clk);
        a1 = 0; drive();
        repeat (12) @(negedge clk);
    endtask

    task automatic set_sw(bit s1, bit s2);
        a1 = s1; a2 = s2; drive();
        repeat (6) @(negedge clk);
    endtask

    initial begin : main
        logic [1:0] e;
        logic [3:0] m;
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (2) @(negedge clk);
        n_chk++;
        if (mem_sel !== 2'd0 || mem_chg !== 1'b0) begin
            n_err++;
            $display("FAIL R1: mem_sel=%0d chg=%0b expected 0 0", mem_sel, mem_chg);
        end
        boot(2'd0, 0, 4'hF, 8'd20, 0, 0);
        chk("R1 boot momentary", mem_sel, 2'd0);

        // R3 cycling with wrap, mask 1111
        press(12); chk("R3 A->B", mem_sel, 2'd1);
        press(12); chk("R3 B->C", mem_sel, 2'd2);
        press(12); chk("R3 C->D", mem_sel, 2'd3);
        press(12); chk("R3 wrap D->A", mem_sel, 2'd0);
        // R12 short press ignored, long hold counts once
        press(2);  chk("R12 short press", mem_sel, 2'd0);
        press(40); chk("R12 long hold once", mem_sel, 2'd1);
        // R10 por_hold
        por_hold = 1'b1;
        press(12); chk("R10 press during hold", mem_sel, 2'd1);
        por_hold = 1'b0;
        press(12); chk("R10 press after hold", mem_sel, 2'd2);

        // R4 single valid memory
        boot(2'd0, 0, 4'h1, 8'd20, 0, 0);
        press(12); chk("R4 single valid", mem_sel, 2'd0);
        // R3 gap in mask: A,C valid
        boot(2'd0, 0, 4'h5, 8'd20, 0, 0);
        press(12); chk("R3 skip invalid B", mem_sel, 2'd2);
        press(12); chk("R3 wrap from C", mem_sel, 2'd0);

        // R5 R9 momentary D-only, pull-down
        boot(2'd1, 0, 4'hF, 8'd20, 0, 0);
        press(12); chk("R6 A->B", mem_sel, 2'd1);
        set_sw(0, 1); chk("R5 force D", mem_sel, 2'd3);
        press(12); chk("R5 press ignored in D", mem_sel, 2'd3);
        a2 = 0; drive();
        repeat (15) @(negedge clk); chk("R9 still D in window", mem_sel, 2'd3);
        a2 = 1; drive(); @(negedge clk); a2 = 0; drive();
        repeat (15) @(negedge clk); chk("R9 closure restarts window", mem_sel, 2'd3);
        repeat (20) @(negedge clk); chk("R5 restore prior memory", mem_sel, 2'd1);

        // R6 R2 pull-up D-only cycle A,B,C
        boot(2'd1, 1, 4'hF, 8'd5, 0, 0);
        chk("R2 pull-up idle boot", mem_sel, 2'd0);
        press(12); press(12); chk("R6 reach C", mem_sel, 2'd2);
        press(12); chk("R6 D skipped, wrap", mem_sel, 2'd0);
        set_sw(0, 1); chk("R2 pull-up low forces D", mem_sel, 2'd3);
        // R6 three valid: cycle A,B
        boot(2'd1, 0, 4'h7, 8'd5, 0, 0);
        press(12); press(12); chk("R6 three valid wraps after B", mem_sel, 2'd0);

        // R7 static mapping and intermediate path
        boot(2'd2, 0, 4'hF, 8'd5, 0, 1);
        chk("R7 start in C", mem_sel, 2'd2);
        set_sw(0, 0); chk("R7 00->A", mem_sel, 2'd0);
        set_sw(1, 0); chk("R7 intermediate B", mem_sel, 2'd1);
        set_sw(1, 1); chk("R7 11->D", mem_sel, 2'd3);
        boot(2'd2, 0, 4'hB, 8'd5, 0, 1);
        chk("R7 invalid C falls to A", mem_sel, 2'd0);

        // R8 static D-only
        boot(2'd3, 0, 4'hF, 8'd5, 1, 1);
        chk("R8 boot into D", mem_sel, 2'd3);
        set_sw(0, 1); chk("R8 switch1 ignored in D", mem_sel, 2'd3);
        a1 = 1; a2 = 0; drive();
        repeat (16) @(negedge clk); chk("R8 leave D to B", mem_sel, 2'd1);
        set_sw(0, 0); chk("R8 none -> A", mem_sel, 2'd0);

        // Random momentary blocks
        for (int b = 0; b < 6; b++) begin
            m = 4'($urandom) | 4'b0001;
            boot(2'((b % 2)), 0, m, 8'd5, 0, 0);
            e = 2'd0;
            for (int k = 0; k < 8; k++) begin
                press(8 + int'($urandom % 6));
                e = exp_next(e, m, bit'(b % 2));
                chk((b % 2) ? "R6 random" : "R3 random", mem_sel, e);
            end
        end
        // Random static settings
        for (int b = 0; b < 3; b++) begin
            m = 4'($urandom);
            boot(2'd2, bit'(b == 1), m, 8'd5, 0, 0);
            for (int k = 0; k < 12; k++) begin
                bit r1, r2;
                r1 = bit'($urandom); r2 = bit'($urandom);
                set_sw(r1, r2);
                chk("R7 random", mem_sel, exp_static(r1, r2, m));
            end
        end

        // R11 pulse correspondence over the whole run
        n_chk++;
        if (chg_err != 0) begin
            n_err++;
            $display("FAIL R11: %0d pulse mismatches expected 0", chg_err);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule